// File: doc/BRIEF.md
# LCD Scanline Timing Sequencer

This block produces the line and frame timing of a tile-based LCD controller. A dot counter runs through each scanline and a line counter steps through the frame. On visible lines the block moves through object scan, pixel transfer and horizontal blank. Once the visible lines are done it holds vertical blank until the frame wraps. The drawing engine is not part of this block. The pixel-transfer phase has a fixed length, and a one-cycle start-of-draw strobe marks where a drawing engine would begin.

Software sees four byte registers on a simple register bus: control, status, the current line and the line-compare value. Reads are combinational and writes take effect at the clock edge. Bit 7 of control switches the LCD on. While that bit is clear, every counter freezes and no request pulse is produced. Any control write with bit 7 set restarts the frame timing at line 0, dot 0. The block produces two interrupt request pulses, one for vertical blank and one for status events. An interrupt controller outside the block collects them.

Top module: `lcd_line_sequencer`

## Requirements
- R1: A scanline lasts 456 clock cycles. When the line ends, the line register (0xFF44) increments, and after line 153 it returns to 0.
- R2: Status bits 1:0 hold the mode: 0 is horizontal blank, 1 is vertical blank, 2 is object scan and 3 is pixel transfer. On lines below 144, counting edges from the enabling edge of a line, the mode reads 2 after edge 1, 3 after edge 82 and 0 after edge 254.
- R3: `drawStart` is high for exactly the one cycle in which the mode first reads 3 on a line.
- R4: On line 144, the mode becomes 1 one edge into the line and `vblankIrq` pulses for one cycle at the same time. The mode stays 1 through line 153.
- R5: `statIrq` pulses for one cycle when the mode enters 2 and when it enters 0 on a visible line.
- R6: At the edge that ends a line, the new line number is compared with the compare register (0xFF45). Status bit 2 is set and `statIrq` pulses when they match. Bit 2 is cleared when they do not match.
- R7: While control bit 7 is 0, the line value and the mode hold, and `statIrq`, `vblankIrq` and `drawStart` stay low.
- R8: A control write with bit 7 set clears the line register and restarts the dot count. The next edge enters mode 2 with a `statIrq` pulse, and the line value reaches 1 after 456 edges.
- R9: Register addresses are: control 0xFF40, all 8 bits read and write; line 0xFF44, read-only, bus writes ignored; compare 0xFF45, read and write. Any other address reads 0.
- R10: Bus writes to status (0xFF41) store only bits 6:3. Bus writes never change bits 2:0, and bit 7 always reads 0.
- R11: After reset, every register reads 0 and all three pulse outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, one dot per cycle |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 16 | Register bus address |
| busWr | input | 1 | Write strobe, sampled at the clock edge |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Combinational read data for `busAddr` |
| vblankIrq | output | 1 | One-cycle vertical-blank request |
| statIrq | output | 1 | One-cycle status request |
| drawStart | output | 1 | One-cycle pixel-transfer start strobe |

## Verification
The assertions assume that the bus drives `busWr`, `busAddr` and `busWdata` with defined values, and that a single write touches only one register. The stimulus changes the bus only between clock edges and never leaves `busWr` high for more than one edge. It enables the LCD only after the compare register has been loaded, so the line and mode checks start from a known dot count.

// File: rtl/lcdseq_pkg.sv
package lcdseq_pkg;
  localparam int DATA_W = 8;

  typedef enum logic [1:0] {
    MODE_HBLANK = 2'd0,
    MODE_VBLANK = 2'd1,
    MODE_SCAN   = 2'd2,
    MODE_DRAW   = 2'd3
  } lcdMode_e;

  // control -> datapath strobes, valid for one cycle
  typedef struct packed {
    logic enterScan;
    logic enterDraw;
    logic enterHblank;
    logic enterVblank;
    logic lineEnd;
  } seqStrobe_t;
endpackage

// File: rtl/lcdseq_ctrl.sv
module lcdseq_ctrl
  import lcdseq_pkg::*;
#(
  parameter int DOTS_PER_LINE    = 456,
  parameter int DRAW_START_DOT   = 81,
  parameter int HBLANK_START_DOT = 253,
  parameter int VISIBLE_LINES    = 144
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lcdOn,
  input  logic              restart,
  input  logic [DATA_W-1:0] ly,
  output seqStrobe_t        strb
);
  localparam int DOT_W = $clog2(DOTS_PER_LINE);
  localparam logic [DOT_W-1:0]  DOT_LAST   = DOT_W'(DOTS_PER_LINE - 1);
  localparam logic [DOT_W-1:0]  DOT_DRAW   = DOT_W'(DRAW_START_DOT);
  localparam logic [DOT_W-1:0]  DOT_HBLANK = DOT_W'(HBLANK_START_DOT);
  localparam logic [DATA_W-1:0] LY_VBLANK  = DATA_W'(VISIBLE_LINES);

  logic [DOT_W-1:0] dotCnt;
  logic visible;

  always_ff @(posedge clk) begin
    if (!rstN)             dotCnt <= '0;
    else if (restart)      dotCnt <= '0;
    else if (lcdOn)        dotCnt <= (dotCnt == DOT_LAST) ? '0 : dotCnt + 1'b1;
  end

  assign visible = (ly < LY_VBLANK);

  always_comb begin
    strb             = '0;
    strb.enterScan   = lcdOn && visible && (dotCnt == '0);
    strb.enterDraw   = lcdOn && visible && (dotCnt == DOT_DRAW);
    strb.enterHblank = lcdOn && visible && (dotCnt == DOT_HBLANK);
    strb.enterVblank = lcdOn && (ly == LY_VBLANK) && (dotCnt == '0);
    strb.lineEnd     = lcdOn && (dotCnt == DOT_LAST);
  end

  // R1: dot counter never leaves the line
  assert_dot_range_R1: assert property (@(posedge clk) disable iff (!rstN)
    dotCnt <= DOT_LAST);
  // R2: at most one mode entry per cycle
  assert_one_entry_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.enterScan, strb.enterDraw, strb.enterHblank, strb.enterVblank}));
  // R7: dot count frozen while off
  assert_dot_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!lcdOn && !restart) |=> $stable(dotCnt));
  // R8: restart returns dot count to zero
  assert_dot_restart_R8: assert property (@(posedge clk) disable iff (!rstN)
    restart |=> (dotCnt == '0));
endmodule

// File: rtl/lcdseq_regs.sv
module lcdseq_regs
  import lcdseq_pkg::*;
#(
  parameter int ADDR_W        = 16,
  parameter logic [15:0] CTRL_ADDR = 16'hFF40,
  parameter logic [15:0] STAT_ADDR = 16'hFF41,
  parameter logic [15:0] LY_ADDR   = 16'hFF44,
  parameter logic [15:0] LYC_ADDR  = 16'hFF45,
  parameter int VISIBLE_LINES = 144,
  parameter int TOTAL_LINES   = 154
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  seqStrobe_t        strb,
  output logic              lcdOn,
  output logic              restart,
  output logic [DATA_W-1:0] ly,
  output logic              vblankIrq,
  output logic              statIrq,
  output logic              drawStart
);
  localparam logic [DATA_W-1:0] LY_LAST   = DATA_W'(TOTAL_LINES - 1);
  localparam logic [DATA_W-1:0] LY_VBLANK = DATA_W'(VISIBLE_LINES);

  logic [DATA_W-1:0] ctrlReg, lycReg, nextLy;
  logic [3:0]        statEn;
  logic              coin, lycHit;
  lcdMode_e          mode;

  assign lcdOn   = ctrlReg[7];
  assign restart = busWr && (busAddr == CTRL_ADDR) && busWdata[7];
  assign nextLy  = (ly == LY_LAST) ? '0 : ly + 1'b1;
  assign lycHit  = (nextLy == lycReg);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg   <= '0;
      lycReg    <= '0;
      statEn    <= '0;
      ly        <= '0;
      coin      <= 1'b0;
      mode      <= MODE_HBLANK;
      vblankIrq <= 1'b0;
      statIrq   <= 1'b0;
      drawStart <= 1'b0;
    end else begin
      if (busWr && busAddr == CTRL_ADDR) ctrlReg <= busWdata;
      if (busWr && busAddr == LYC_ADDR)  lycReg  <= busWdata;
      if (busWr && busAddr == STAT_ADDR) statEn  <= busWdata[6:3];
      vblankIrq <= 1'b0;
      statIrq   <= 1'b0;
      drawStart <= 1'b0;
      if (restart) begin
        ly <= '0;
      end else begin
        if (strb.lineEnd) begin
          ly   <= nextLy;
          coin <= lycHit;
        end
        if (strb.enterScan)   mode <= MODE_SCAN;
        if (strb.enterDraw)   mode <= MODE_DRAW;
        if (strb.enterHblank) mode <= MODE_HBLANK;
        if (strb.enterVblank) mode <= MODE_VBLANK;
        vblankIrq <= strb.enterVblank;
        drawStart <= strb.enterDraw;
        statIrq   <= strb.enterScan || strb.enterHblank || (strb.lineEnd && lycHit);
      end
    end
  end

  always_comb begin
    unique case (busAddr)
      CTRL_ADDR: busRdata = ctrlReg;
      STAT_ADDR: busRdata = {1'b0, statEn, coin, mode};
      LY_ADDR:   busRdata = ly;
      LYC_ADDR:  busRdata = lycReg;
      default:   busRdata = '0;
    endcase
  end

  // R1: line counter stays inside the frame
  assert_ly_range_R1: assert property (@(posedge clk) disable iff (!rstN)
    ly <= LY_LAST);
  // R4: vertical-blank request coincides with vertical-blank mode
  assert_vblank_mode_R4: assert property (@(posedge clk) disable iff (!rstN)
    vblankIrq |-> (mode == MODE_VBLANK));
  // R3: draw strobe only with pixel-transfer mode
  assert_draw_mode_R3: assert property (@(posedge clk) disable iff (!rstN)
    drawStart |-> (mode == MODE_DRAW));
  // R7: nothing moves while disabled
  assert_hold_off_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!lcdOn && !restart) |=> ($stable(ly) && !statIrq && !vblankIrq && !drawStart));
  // R8: enabling control write clears the line
  assert_ly_restart_R8: assert property (@(posedge clk) disable iff (!rstN)
    restart |=> (ly == '0));
endmodule

// File: rtl/lcd_line_sequencer.sv
module lcd_line_sequencer
  import lcdseq_pkg::*;
#(
  parameter int DOTS_PER_LINE    = 456,
  parameter int DRAW_START_DOT   = 81,
  parameter int HBLANK_START_DOT = 253,
  parameter int VISIBLE_LINES    = 144,
  parameter int TOTAL_LINES      = 154
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [15:0] busAddr,
  input  logic        busWr,
  input  logic [7:0]  busWdata,
  output logic [7:0]  busRdata,
  output logic        vblankIrq,
  output logic        statIrq,
  output logic        drawStart
);
  seqStrobe_t        strb;
  logic              lcdOn, restart;
  logic [DATA_W-1:0] ly;

  lcdseq_ctrl #(
    .DOTS_PER_LINE(DOTS_PER_LINE), .DRAW_START_DOT(DRAW_START_DOT),
    .HBLANK_START_DOT(HBLANK_START_DOT), .VISIBLE_LINES(VISIBLE_LINES)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .lcdOn(lcdOn), .restart(restart), .ly(ly), .strb(strb)
  );

  lcdseq_regs #(
    .ADDR_W(16), .VISIBLE_LINES(VISIBLE_LINES), .TOTAL_LINES(TOTAL_LINES)
  ) uRegs (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busWdata(busWdata),
    .busRdata(busRdata), .strb(strb), .lcdOn(lcdOn), .restart(restart), .ly(ly),
    .vblankIrq(vblankIrq), .statIrq(statIrq), .drawStart(drawStart)
  );
endmodule

// File: tb/tb_lcd_line_sequencer.sv
`timescale 1ns/1ps
module tb_lcd_line_sequencer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] busAddr = 16'h0000;
  logic        busWr = 1'b0;
  logic [7:0]  busWdata = 8'h00;
  logic [7:0]  busRdata;
  logic        vblankIrq, statIrq, drawStart;

  int nChecks = 0, nFails = 0, edgeCnt = 0, base = 0;
  logic [7:0] rv;

  always #2.5 clk = ~clk;
  always @(posedge clk) edgeCnt <= edgeCnt + 1;

  lcd_line_sequencer dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busWdata(busWdata),
    .busRdata(busRdata), .vblankIrq(vblankIrq), .statIrq(statIrq), .drawStart(drawStart)
  );

  // {edge offset, ly, mode, statIrq, vblankIrq, drawStart, coincidence}
  localparam int NV = 23;
  localparam logic [33:0] VEC [NV] = '{
    {20'd0,     8'd0,   2'd0, 1'b0, 1'b0, 1'b0, 1'b0},
    {20'd1,     8'd0,   2'd2, 1'b1, 1'b0, 1'b0, 1'b0},
    {20'd2,     8'd0,   2'd2, 1'b0, 1'b0, 1'b0, 1'b0},
    {20'd81,    8'd0,   2'd2, 1'b0, 1'b0, 1'b0, 1'b0},
    {20'd82,    8'd0,   2'd3, 1'b0, 1'b0, 1'b1, 1'b0},
    {20'd83,    8'd0,   2'd3, 1'b0, 1'b0, 1'b0, 1'b0},
    {20'd253,   8'd0,   2'd3, 1'b0, 1'b0, 1'b0, 1'b0},
    {20'd254,   8'd0,   2'd0, 1'b1, 1'b0, 1'b0, 1'b0},
    {20'd455,   8'd0,   2'd0, 1'b0, 1'b0, 1'b0, 1'b0},
    {20'd456,   8'd1,   2'd0, 1'b0, 1'b0, 1'b0, 1'b0},
    {20'd457,   8'd1,   2'd2, 1'b1, 1'b0, 1'b0, 1'b0},
    {20'd2279,  8'd4,   2'd0, 1'b0, 1'b0, 1'b0, 1'b0},
    {20'd2280,  8'd5,   2'd0, 1'b1, 1'b0, 1'b0, 1'b1},
    {20'd2281,  8'd5,   2'd2, 1'b1, 1'b0, 1'b0, 1'b1},
    {20'd2736,  8'd6,   2'd0, 1'b0, 1'b0, 1'b0, 1'b0},
    {20'd65664, 8'd144, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0},
    {20'd65665, 8'd144, 2'd1, 1'b0, 1'b1, 1'b0, 1'b0},
    {20'd65666, 8'd144, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0},
    {20'd66120, 8'd145, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0},
    {20'd70223, 8'd153, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0},
    {20'd70224, 8'd0,   2'd1, 1'b0, 1'b0, 1'b0, 1'b0},
    {20'd70225, 8'd0,   2'd2, 1'b1, 1'b0, 1'b0, 1'b0},
    {20'd70306, 8'd0,   2'd3, 1'b0, 1'b0, 1'b1, 1'b0}
  };

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h at edge %0d", req, act, exp, edgeCnt - base);
    end
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    busAddr = a;
    #0.2;
    d = busRdata;
  endtask

  // called between edges; returns at the negedge after the write edge
  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic advanceTo(input int t);
    while (edgeCnt - base < t) @(negedge clk);
  endtask

  initial begin
    #(150000 * 5);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [2:0] heldMode;
    logic [7:0] heldLy;
    int pulses;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11 reset state
    rd(16'hFF40, rv); chk("R11 ctrl", rv, 8'h00);
    rd(16'hFF41, rv); chk("R11 stat", rv, 8'h00);
    rd(16'hFF44, rv); chk("R11 ly", rv, 8'h00);
    rd(16'hFF45, rv); chk("R11 lyc", rv, 8'h00);
    chk("R11 pulses", {statIrq, vblankIrq, drawStart}, 0);
    // R9 register map
    wr(16'hFF44, 8'h55); rd(16'hFF44, rv); chk("R9 ly read-only", rv, 8'h00);
    wr(16'hFF40, 8'h13); rd(16'hFF40, rv); chk("R9 ctrl rw", rv, 8'h13);
    wr(16'hFF45, 8'h05); rd(16'hFF45, rv); chk("R9 lyc rw", rv, 8'h05);
    rd(16'hFF42, rv); chk("R9 unmapped", rv, 8'h00);
    // R10 status write mask
    wr(16'hFF41, 8'hFF); rd(16'hFF41, rv); chk("R10 stat mask", rv, 8'h78);
    // R7 disabled: nothing advances
    repeat (500) @(negedge clk);
    rd(16'hFF44, rv); chk("R7 ly idle", rv, 8'h00);
    rd(16'hFF41, rv); chk("R7 mode idle", rv, 8'h78);

    // enable; write edge is offset 0
    wr(16'hFF40, 8'h80);
    base = edgeCnt;
    rd(16'hFF40, rv); chk("R9 ctrl enable", rv, 8'h80);
    for (int i = 0; i < NV; i++) begin
      advanceTo(int'(VEC[i][33:14]));
      rd(16'hFF44, rv); chk("R1 ly", rv, VEC[i][13:6]);
      rd(16'hFF41, rv);
      chk("R2 mode", rv[1:0], VEC[i][5:4]);
      chk("R6 coincidence", rv[2], VEC[i][0]);
      chk("R5 statIrq", statIrq, VEC[i][3]);
      chk("R4 vblankIrq", vblankIrq, VEC[i][2]);
      chk("R3 drawStart", drawStart, VEC[i][1]);
    end

    // R7: disable mid-line on line 3, pixel transfer
    advanceTo(70224 + 3 * 456 + 100);
    wr(16'hFF40, 8'h00);
    rd(16'hFF44, heldLy); chk("R7 ly before hold", heldLy, 8'd3);
    rd(16'hFF41, rv); heldMode = rv[2:0]; chk("R7 mode before hold", heldMode[1:0], 2'd3);
    pulses = 0;
    for (int k = 0; k < 600; k++) begin
      @(negedge clk);
      if (statIrq || vblankIrq || drawStart) pulses++;
    end
    chk("R7 no pulses while off", pulses, 0);
    rd(16'hFF44, rv); chk("R7 ly held", rv, heldLy);
    rd(16'hFF41, rv); chk("R7 mode held", rv[2:0], heldMode);

    // R8: enabling write restarts the frame
    wr(16'hFF40, 8'h80);
    base = edgeCnt;
    rd(16'hFF44, rv); chk("R8 ly cleared", rv, 8'd0);
    rd(16'hFF41, rv); chk("R8 mode unchanged on write edge", rv[1:0], 2'd3);
    advanceTo(1);
    rd(16'hFF41, rv); chk("R8 scan entry", rv[1:0], 2'd2);
    chk("R8 statIrq on restart", statIrq, 1);
    advanceTo(455);
    rd(16'hFF44, rv); chk("R8 line 0 full length", rv, 8'd0);
    advanceTo(456);
    rd(16'hFF44, rv); chk("R8 line 1 after 456", rv, 8'd1);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule